// File: doc/BRIEF.md
# Interleaved ADC Channel Demultiplexer

This block sits behind a bank of ADC lanes that sample the outputs of analog multiplexers. Each lane carries eight detector channels in a fixed rotation, one channel per conversion. The lane rate is 16 Msps, so every channel is visited once per 500 ns, or 2 Msps per channel. With four lanes the block rebuilds the streams of 32 channels. Each accepted conversion is tagged with the phase of the rotation it belongs to. The phase comes from a local rotating counter, and that counter is kept in step with the analog side by a frame marker.

The marker travels alongside the first conversion of a rotation. When it arrives, it forces that conversion to phase 0. If the local counter did not expect a new rotation at that point, a sticky slip flag rises. Every output word carries the four lane samples together with their channel numbers. It also carries a rotation-end tick and a rotation count, which downstream logic uses as a coarse timestamp.

Top module: `adcdmx_top`

## Requirements
- R1: After reset, out_valid and phase_error are 0. The first accepted conversion gets phase 0 and a stamp of 0.
- R2: A conversion accepted with in_valid in one clock appears with out_valid=1 exactly one clock later. out_data holds the input word unchanged. Lane k is carried in bits [k*12 +: 12] of both in_data and out_data.
- R3: The channel number of lane k is k*8 + phase. It sits in bits [k*5 +: 5] of out_chan.
- R4: The phase advances by one for each accepted conversion and wraps from 7 to 0. Clocks with in_valid=0 do not advance it.
- R5: A conversion accepted with in_frame=1 is given phase 0. The conversions that follow it continue from 1.
- R6: phase_error goes to 1 when in_frame is accepted but the previous accepted conversion was not phase 7. Right after reset, a frame marker counts as aligned. Once set, phase_error stays 1 until reset.
- R7: in_frame has no effect in a clock where in_valid=0.
- R8: out_tick is 1 exactly on output words whose phase is 7.
- R9: out_stamp carries the number of phase-7 conversions accepted before the current one. A resynchronised rotation that is cut short does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One conversion on all lanes this clock |
| in_frame | input | 1 | Conversion is the start of a rotation |
| in_data | input | 48 | Four 12-bit lane samples |
| out_valid | output | 1 | Output word valid |
| out_chan | output | 20 | Four 5-bit channel numbers |
| out_data | output | 48 | Four 12-bit samples |
| out_tick | output | 1 | Word closes a rotation (2 MHz tick) |
| out_stamp | output | 32 | Rotation count for timestamping |
| phase_error | output | 1 | Sticky rotation slip flag |

## Verification
The bench interleaves idle clocks with conversions. A design that advanced the phase on idle clocks would assign every later sample to the wrong channel. It sends frame markers without a conversion alongside them. A design that honoured those markers would restart the rotation early. It places one frame marker exactly on a rotation boundary and one in the middle of a rotation. A wrong slip test would either raise a false error or miss the slip. It would also bump the stamp for a rotation cut short. A second reset checks that the sticky flag and the rotation count both clear.

// File: rtl/adcdmx_pkg.sv
package adcdmx_pkg;

    localparam int DEF_LANES    = 4;
    localparam int DEF_PHASE_N  = 8;
    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_STAMP_W  = 32;

    // classification of a frame marker against the local rotation
    typedef enum logic [1:0] {
        SYNC_NONE    = 2'd0,
        SYNC_ALIGNED = 2'd1,
        SYNC_SLIP    = 2'd2
    } sync_e;

endpackage

// File: rtl/adcdmx_phase_track.sv
module adcdmx_phase_track
    import adcdmx_pkg::*;
#(
    parameter int PHASE_N = DEF_PHASE_N,
    parameter int STAMP_W = DEF_STAMP_W,
    localparam int PH_W   = (PHASE_N > 1) ? $clog2(PHASE_N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               frame,
    output logic [PH_W-1:0]    use_phase,
    output logic               rot_end,
    output logic [STAMP_W-1:0] cur_stamp,
    output logic               slip_q
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASE_N - 1);

    typedef struct packed {
        logic [PH_W-1:0]    phase;
        logic [STAMP_W-1:0] stamp;
        logic               slip;
    } trk_t;

    trk_t  st_d, st_q;
    sync_e sync_d;

    always_comb begin
        st_d   = st_q;
        sync_d = SYNC_NONE;
        if (accept && frame) begin
            sync_d = (st_q.phase == '0) ? SYNC_ALIGNED : SYNC_SLIP;
        end
        use_phase = (sync_d != SYNC_NONE) ? '0 : st_q.phase;
        rot_end   = (use_phase == LAST_PH);
        cur_stamp = st_q.stamp;
        if (accept) begin
            st_d.phase = rot_end ? '0 : use_phase + PH_W'(1);
            if (rot_end) begin
                st_d.stamp = st_q.stamp + STAMP_W'(1);
            end
            if (sync_d == SYNC_SLIP) begin
                st_d.slip = 1'b1;
            end
        end
        slip_q = st_q.slip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adcdmx_lane.sv
module adcdmx_lane #(
    parameter int LANE     = 0,
    parameter int PHASE_N  = 8,
    parameter int SAMPLE_W = 12,
    parameter int CH_W     = 5,
    localparam int PH_W    = (PHASE_N > 1) ? $clog2(PHASE_N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [PH_W-1:0]     phase,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [CH_W-1:0]     chan_q,
    output logic [SAMPLE_W-1:0] data_q
);

    localparam logic [CH_W-1:0] BASE = CH_W'(LANE * PHASE_N);

    typedef struct packed {
        logic [CH_W-1:0]     chan;
        logic [SAMPLE_W-1:0] data;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (accept) begin
            ln_d.chan = BASE + CH_W'(phase);
            ln_d.data = sample;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign chan_q = ln_q.chan;
    assign data_q = ln_q.data;

endmodule

// File: rtl/adcdmx_top.sv
module adcdmx_top
    import adcdmx_pkg::*;
#(
    parameter int LANES    = DEF_LANES,
    parameter int PHASE_N  = DEF_PHASE_N,
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int STAMP_W  = DEF_STAMP_W,
    localparam int CH_W    = $clog2(LANES * PHASE_N),
    localparam int PH_W    = (PHASE_N > 1) ? $clog2(PHASE_N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_frame,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    output logic                      out_valid,
    output logic [LANES*CH_W-1:0]     out_chan,
    output logic [LANES*SAMPLE_W-1:0] out_data,
    output logic                      out_tick,
    output logic [STAMP_W-1:0]        out_stamp,
    output logic                      phase_error
);

    typedef struct packed {
        logic               valid;
        logic               tick;
        logic [STAMP_W-1:0] stamp;
    } hdr_t;

    hdr_t hdr_d, hdr_q;

    logic [PH_W-1:0]    use_phase;
    logic               rot_end;
    logic [STAMP_W-1:0] cur_stamp;

    adcdmx_phase_track #(
        .PHASE_N (PHASE_N),
        .STAMP_W (STAMP_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (in_valid),
        .frame     (in_frame),
        .use_phase (use_phase),
        .rot_end   (rot_end),
        .cur_stamp (cur_stamp),
        .slip_q    (phase_error)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adcdmx_lane #(
            .LANE     (g),
            .PHASE_N  (PHASE_N),
            .SAMPLE_W (SAMPLE_W),
            .CH_W     (CH_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .accept (in_valid),
            .phase  (use_phase),
            .sample (in_data[g*SAMPLE_W +: SAMPLE_W]),
            .chan_q (out_chan[g*CH_W +: CH_W]),
            .data_q (out_data[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_comb begin
        hdr_d       = hdr_q;
        hdr_d.valid = in_valid;
        hdr_d.tick  = in_valid && rot_end;
        if (in_valid) begin
            hdr_d.stamp = cur_stamp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else begin
            hdr_q <= hdr_d;
        end
    end

    assign out_valid = hdr_q.valid;
    assign out_tick  = hdr_q.tick;
    assign out_stamp = hdr_q.stamp;

endmodule

// File: rtl/adcdmx_checker.sv
module adcdmx_checker #(
    parameter int LANES   = 4,
    parameter int PHASE_N = 8,
    parameter int CH_W    = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_frame,
    input logic                  out_valid,
    input logic [LANES*CH_W-1:0] out_chan,
    input logic                  out_tick,
    input logic                  phase_error
);

    AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_LANE0_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan[CH_W-1:0] < CH_W'(PHASE_N)));  // R3
    for (genvar l = 1; l < LANES; l++) begin : g_step
        AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_chan[l*CH_W +: CH_W] ==
                           out_chan[(l-1)*CH_W +: CH_W] + CH_W'(PHASE_N)));  // R3
    end
    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_frame) |=> (out_chan[CH_W-1:0] == '0));  // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        phase_error |=> phase_error);  // R6
    AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !phase_error) |=> !phase_error);  // R7
    AST_TICK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> (out_valid && out_chan[CH_W-1:0] == CH_W'(PHASE_N - 1)));  // R8

endmodule

bind adcdmx_top adcdmx_checker #(
    .LANES   (LANES),
    .PHASE_N (PHASE_N),
    .CH_W    (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_frame    (in_frame),
    .out_valid   (out_valid),
    .out_chan    (out_chan),
    .out_tick    (out_tick),
    .phase_error (phase_error)
);

// File: tb/tb_adcdmx_top.sv
module tb_adcdmx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_frame = 1'b0;
    logic [47:0] in_data = '0;
    logic        out_valid;
    logic [19:0] out_chan;
    logic [47:0] out_data;
    logic        out_tick;
    logic [31:0] out_stamp;
    logic        phase_error;

    always #4 clk = ~clk;

    adcdmx_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_frame    (in_frame),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_chan    (out_chan),
        .out_data    (out_data),
        .out_tick    (out_tick),
        .out_stamp   (out_stamp),
        .phase_error (phase_error)
    );

    typedef struct {
        logic [47:0] data;
        int          ph;
        logic        tick;
        logic [31:0] stamp;
        logic        err;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_run = 0;
    int    n_fail = 0;
    int    ph_m = 0;
    int    stamp_m = 0;
    logic  err_m = 1'b0;
    int    k_data = 0;
    bit    done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic frame, input string tag);
        item_t it;
        int    ph;
        @(negedge clk);
        k_data++;
        in_valid = 1'b1;
        in_frame = frame;
        in_data  = (48'(k_data) * 48'h0001_0003_0007) ^ 48'hA5A5_5A5A_C3C3;
        ph = frame ? 0 : ph_m;
        if (frame && ph_m != 0) err_m = 1'b1;
        it.data  = in_data;
        it.ph    = ph;
        it.tick  = (ph == 7);
        it.stamp = 32'(stamp_m);
        it.err   = err_m;
        it.tag   = tag;
        q.push_back(it);
        if (ph == 7) stamp_m++;
        ph_m = (ph + 1) % 8;
    endtask

    task automatic idle(input logic frame);
        @(negedge clk);
        in_valid = 1'b0;
        in_frame = frame;
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        in_frame = 1'b0;
        rst_n = 1'b0;
        ph_m = 0;
        stamp_m = 0;
        err_m = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        chk(phase_error == 1'b0, "R1", "phase_error in reset", longint'(phase_error), 0);
        rst_n = 1'b1;
    endtask

    // monitor: pops one expected item per valid output word
    always begin
        @(posedge clk);
        #1;
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                item_t e;
                e = q.pop_front();
                chk(out_data == e.data, "R2", "data", longint'(out_data), longint'(e.data));
                for (int l = 0; l < 4; l++) begin
                    chk(out_chan[l*5 +: 5] == 5'(l*8 + e.ph), {"R3/", e.tag}, "chan",
                        longint'(out_chan[l*5 +: 5]), longint'(l*8 + e.ph));
                end
                chk(out_tick == e.tick, "R8", "tick", longint'(out_tick), longint'(e.tick));
                chk(out_stamp == e.stamp, "R9", "stamp", longint'(out_stamp), longint'(e.stamp));
                chk(phase_error == e.err, "R6", "phase_error", longint'(phase_error),
                    longint'(e.err));
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        push(1'b0, "R1");
        for (int i = 0; i < 19; i++) push(1'b0, "R4");
        // R4: idle clocks must not advance the phase
        idle(1'b0); idle(1'b0); idle(1'b0);
        for (int i = 0; i < 5; i++) begin
            push(1'b0, "R4");
            idle(1'b0);
        end
        // R7: frame marker without a conversion is ignored
        idle(1'b1); idle(1'b1);
        for (int i = 0; i < 3; i++) push(1'b0, "R7");
        // R5: aligned marker on a rotation boundary, no error expected
        while (ph_m != 0) push(1'b0, "R4");
        push(1'b1, "R5");
        for (int i = 0; i < 10; i++) push(1'b0, "R5");
        // R6: marker in mid-rotation, slip flagged and held
        push(1'b0, "R4"); push(1'b0, "R4"); push(1'b0, "R4");
        push(1'b1, "R6");
        for (int i = 0; i < 10; i++) push(1'b0, "R6");
        idle(1'b0); idle(1'b0);
        // R1: second reset clears the slip flag and the stamp
        do_reset();
        for (int i = 0; i < 9; i++) push(1'b0, "R1");
        idle(1'b0);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R2", "queue drained", longint'(q.size()), 0);
        chk(phase_error == 1'b0, "R1", "phase_error after reset", longint'(phase_error), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule